// File: doc/BRIEF.md
# Multi-DAC Zero Detect Flag

This block watches the sample streams feeding four stereo DACs and produces one registered zero flag for an output pin. Each of the eight channels has its own run-length counter of consecutive all-zero samples. A channel reports zero once its run reaches 1024 samples. A DAC's flag rises when both of its channels report zero. It is also forced high while that DAC is powered down or muted, whatever its samples are.

A 3-bit select chooses what drives the pin. The choices are the combined flag of all four DACs, the flag of one chosen DAC, or a constant low. The flag is meant to drive an external mute or status pin, so that downstream analog stages can be silenced while the digital inputs are idle.

Each channel's sample input is a valid/ready stream. The block never applies back-pressure: ready stays high whenever reset is released, so the sender transfers a sample on every cycle in which it asserts valid. Samples are only consumed. The power-down, mute and select inputs are plain level controls.

Top module: `zero_flag_monitor`

## Requirements
- R1: A channel reports zero only after 1024 consecutive accepted samples equal to zero. After 1023 such samples it does not report zero.
- R2: An accepted nonzero sample restarts that channel's run at zero and clears its zero report.
- R3: A cycle with valid low on a channel neither advances nor clears that channel's run, whatever the data lines carry.
- R4: A run saturates at 1024. The channel keeps reporting zero for as long as zero samples continue, with no wrap.
- R5: Channel index c = 2*d + s belongs to DAC d (0..3), where s = 0 is the left channel and s = 1 is the right channel. A DAC's flag is high when both of its channels report zero.
- R6: A DAC's flag is high whenever its power-down bit or its mute bit is set, regardless of sample data.
- R7: The all-DAC flag is the logical AND of the four DAC flags.
- R8: Select coding: 000 selects the all-DAC flag, 001 to 100 select DAC 0 to DAC 3, and 101, 110 and 111 force the output to 0.
- R9: The output is registered. It reflects the select, the controls and the channel state of the previous cycle, and it is 0 during and right after reset.
- R10: Every channel's ready output is high whenever reset is not asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 8 | Per-channel sample valid, bit c for channel c |
| smp_data | input | 192 | Per-channel 24-bit samples, channel c in bits [24c+23:24c] |
| smp_ready | output | 8 | Per-channel ready, always high out of reset |
| dac_pd | input | 4 | Per-DAC power-down, bit d for DAC d |
| dac_mute | input | 4 | Per-DAC mute, bit d for DAC d |
| flag_sel | input | 3 | Output source select |
| zero_flag_o | output | 1 | Registered selected zero flag |

## Verification
The assertions assume that rst_n is held low for at least one clock edge, so that every run counter starts at zero. They also assume that valid, data and the control inputs change only away from the active edge. The bench drives all inputs one time unit after each rising edge and keeps reset low across several edges at the start. The random phase makes nonzero samples rare and drops valid on about half the cycles, so runs reach the threshold and also get broken. It also varies the select and the control bits slowly enough that each flag source is seen both high and low.

// File: rtl/zdf_pkg.sv
package zdf_pkg;
  localparam int NUM_DAC   = 4;
  localparam int SMP_W     = 24;
  localparam int ZERO_RUN  = 1024;
  localparam int SEL_W     = 3;
  localparam int NUM_CH    = 2 * NUM_DAC;

  typedef enum logic [SEL_W-1:0] {
    SEL_ALL  = 3'd0,
    SEL_DAC0 = 3'd1,
    SEL_DAC1 = 3'd2,
    SEL_DAC2 = 3'd3,
    SEL_DAC3 = 3'd4
  } sel_code_e;
endpackage

// File: rtl/zdf_chan_ctr.sv
module zdf_chan_ctr #(
  parameter int SMP_W    = 24,
  parameter int ZERO_RUN = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [SMP_W-1:0] data_i,
  output logic             zero_o
);
  localparam int CW = $clog2(ZERO_RUN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(ZERO_RUN);

  logic [CW-1:0] run_q;
  logic          is_zero;

  assign is_zero = (data_i == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (valid_i) begin
      if (!is_zero)
        run_q <= '0;
      else if (run_q != LIMIT)
        run_q <= run_q + 1'b1;
    end
  end

  assign zero_o = (run_q == LIMIT);

  // R4: the run never goes past the threshold
  p_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LIMIT);

  // R2: a taken nonzero sample empties the run
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !is_zero) |=> (run_q == '0));

  // R3: idle cycles leave the run untouched
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && $past(rst_n)) |=> $stable(run_q));

  // R4: once at the limit, further zeros keep the report up
  p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && (!valid_i || is_zero)) |=> zero_o);
endmodule

// File: rtl/zdf_dac_unit.sv
module zdf_dac_unit #(
  parameter int SMP_W    = 24,
  parameter int ZERO_RUN = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         valid_i,
  input  logic [2*SMP_W-1:0] data_i,
  input  logic               pd_i,
  input  logic               mute_i,
  output logic               flag_o
);
  logic [1:0] ch_zero;

  for (genvar s = 0; s < 2; s++) begin : g_side
    zdf_chan_ctr #(
      .SMP_W   (SMP_W),
      .ZERO_RUN(ZERO_RUN)
    ) ctr_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid_i(valid_i[s]),
      .data_i (data_i[s*SMP_W +: SMP_W]),
      .zero_o (ch_zero[s])
    );
  end

  assign flag_o = (&ch_zero) | pd_i | mute_i;

  // R6: a powered-down or muted DAC always flags
  p_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_i || mute_i) |-> flag_o);

  // R5: an unforced DAC flags only when both sides are idle
  p_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_i && !mute_i && flag_o) |-> (ch_zero == 2'b11));
endmodule

// File: rtl/zdf_out_sel.sv
module zdf_out_sel #(
  parameter int NUM_DAC = 4,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_DAC-1:0] dac_flag_i,
  output logic               flag_o
);
  logic pick;
  logic flag_q;

  always_comb begin
    pick = 1'b0;
    if (sel_i == '0)
      pick = &dac_flag_i;
    for (int i = 0; i < NUM_DAC; i++)
      if (sel_i == SEL_W'(i + 1))
        pick = dac_flag_i[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else
      flag_q <= pick;
  end

  assign flag_o = flag_q;

  // R8: reserved codes hold the pin low
  p_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i > SEL_W'(NUM_DAC)) |=> !flag_o);

  // R7: the combined code follows the AND of all DACs one cycle later
  p_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == '0) |=> (flag_o == $past(&dac_flag_i)));
endmodule

// File: rtl/zero_flag_monitor.sv
module zero_flag_monitor
  import zdf_pkg::*;
#(
  parameter int NDAC   = NUM_DAC,
  parameter int W      = SMP_W,
  parameter int THRESH = ZERO_RUN,
  parameter int SW     = SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*NDAC-1:0] smp_valid,
  input  logic [2*NDAC*W-1:0] smp_data,
  output logic [2*NDAC-1:0] smp_ready,
  input  logic [NDAC-1:0]   dac_pd,
  input  logic [NDAC-1:0]   dac_mute,
  input  logic [SW-1:0]     flag_sel,
  output logic              zero_flag_o
);
  localparam int NCH = 2 * NDAC;

  logic [NDAC-1:0] dac_flag;
  logic [NCH-1:0]  take;

  assign smp_ready = {NCH{rst_n}};
  assign take      = smp_valid & smp_ready;

  for (genvar d = 0; d < NDAC; d++) begin : g_dac
    zdf_dac_unit #(
      .SMP_W   (W),
      .ZERO_RUN(THRESH)
    ) unit_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid_i(take[2*d +: 2]),
      .data_i (smp_data[2*d*W +: 2*W]),
      .pd_i   (dac_pd[d]),
      .mute_i (dac_mute[d]),
      .flag_o (dac_flag[d])
    );
  end

  zdf_out_sel #(
    .NUM_DAC(NDAC),
    .SEL_W  (SW)
  ) sel_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (flag_sel),
    .dac_flag_i(dac_flag),
    .flag_o    (zero_flag_o)
  );

  // R10: the sink never stalls
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready == {NCH{1'b1}});

  // R9: the pin is low on the first cycle after reset
  p_rstlow_r9: assert property (@(posedge clk)
    !rst_n |=> !zero_flag_o);
endmodule

// File: tb/zero_flag_monitor_tb.sv
module zero_flag_monitor_tb_top;
  localparam int ND = 4;
  localparam int NC = 8;
  localparam int W  = 24;
  localparam int TH = 1024;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NC-1:0]   valid = '0;
  logic [NC*W-1:0] data = '0;
  logic [NC-1:0]   ready;
  logic [ND-1:0]   pd = '0;
  logic [ND-1:0]   mute = '0;
  logic [2:0]      sel = 3'd0;
  logic            zflag;

  int mcnt [NC];
  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  zero_flag_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(valid), .smp_data(data),
    .smp_ready(ready), .dac_pd(pd), .dac_mute(mute), .flag_sel(sel),
    .zero_flag_o(zflag)
  );

  function automatic logic expect_flag();
    logic [ND-1:0] df;
    for (int d = 0; d < ND; d++)
      df[d] = ((mcnt[2*d] >= TH) && (mcnt[2*d+1] >= TH)) || pd[d] || mute[d];
    if (sel == 3'd0) return &df;
    if (sel <= 3'd4) return df[sel-1];
    return 1'b0;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    logic e;
    e = expect_flag();
    for (int c = 0; c < NC; c++)
      if (valid[c]) begin
        if (data[c*W +: W] != '0) mcnt[c] = 0;
        else if (mcnt[c] < TH) mcnt[c]++;
      end
    @(posedge clk); #1;
    check(tag, zflag, e);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int c = 0; c < NC; c++) mcnt[c] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset low", zflag, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R9 after reset", zflag, 1'b0);
    check("R10 ready", ready == '1, 1'b1);

    // R1: 1023 zeros leave the flag down, the 1024th raises it a cycle later
    valid = '1; data = '0; sel = 3'd0;
    for (int i = 0; i < TH; i++) step("R1 run");
    check("R1 not yet", zflag, 1'b0);
    step("R7 all flag");
    check("R7 all high", zflag, 1'b1);
    // R4: saturation keeps the flag high
    for (int i = 0; i < 100; i++) step("R4 saturate");
    check("R4 held", zflag, 1'b1);

    // R2: a nonzero sample on DAC1 right (channel 3)
    data[3*W +: W] = 24'h000100;
    step("R2 nonzero");
    data = '0;
    step("R2 cleared");
    check("R2 low", zflag, 1'b0);
    // R5: DAC1 drops, DAC0 stays
    sel = 3'd2; step("R5 dac1 low");
    sel = 3'd1; step("R5 dac0 high");
    // R8: sweep every code
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      step("R8 sweep");
    end
    // R3: invalid cycles with nonzero data change nothing
    valid = '0; data = {NC{24'hFFFFFF}};
    sel = 3'd1;
    for (int i = 0; i < 50; i++) step("R3 idle");
    check("R3 dac0 kept", zflag, 1'b1);
    sel = 3'd2; step("R3 dac1 still low");
    // R6: power-down and mute force DAC1
    pd[1] = 1'b1; step("R6 pd"); step("R6 pd seen");
    check("R6 pd high", zflag, 1'b1);
    pd[1] = 1'b0; mute[1] = 1'b1; step("R6 mute"); step("R6 mute seen");
    check("R6 mute high", zflag, 1'b1);
    mute[1] = 1'b0; step("R6 release"); step("R6 release seen");
    check("R6 release low", zflag, 1'b0);

    // random mix checking R5/R7/R8 against the model
    for (int i = 0; i < 40000; i++) begin
      for (int c = 0; c < NC; c++) begin
        valid[c] = ($urandom % 2) == 0;
        data[c*W +: W] = (($urandom % 4000) == 0) ? (24'($urandom) | 24'h1) : 24'h0;
      end
      if (($urandom % 50) == 0) sel = 3'($urandom % 8);
      if (($urandom % 500) == 0) pd[$urandom % ND] ^= 1'b1;
      if (($urandom % 500) == 0) mute[$urandom % ND] ^= 1'b1;
      step("R5/R7/R8 random");
    end
    check("R10 ready end", ready == '1, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule